// File: doc/BRIEF.md
# Synthesizer Counter Path with Debug Selector

This block is a digital model of the counting path of a crystal-referenced frequency synthesizer. It has three dividers. The first is a fixed divide-by-16 on the crystal clock, which produces the comparison clock for the phase detector. The second is a programmable feedback counter on the oscillator clock, which divides by M. The third is an output divider, which divides the oscillator clock by 1, 2, 4 or 8 with equal high and low times. A 3-bit test code selects one of eight internal signals for a single-ended debug pin. Two of these codes move the feedback counter or the output divider onto the slow serial clock. The dividers can then be checked at low speed, without a working loop.

The block runs on one fast system clock. Each external clock is presented as a one-cycle edge strobe: every strobe stands for one edge, rising or falling, of that clock. A divider of ratio D therefore flips its output level every D strobes, which gives a period of D source periods and a 50% duty cycle. Divide-by-1 simply mirrors the source phase. The feedback counter advances only on rising edges. It is tracked by a phase register per source. Every output level is registered and changes in the system cycle after the strobe that caused it. The debug selector is combinational.

The half-period dividers use two states. HALF_LOW and HALF_HIGH swap on the terminal-count transition, which is the strobe that completes the current half. The feedback counter also uses two states. FB_RUN goes to FB_FIRE when the count reaches one. FB_FIRE goes back to FB_RUN on the next rising edge and reloads M−1. FB_FIRE is held when M is below 2.

Top module: `synth_divchain`

## Requirements
- R1: `ref_out` starts low after reset and flips on every 16th `xtal_edge` strobe. It is a divide-by-16 of the crystal clock with 50% duty.
- R2: `fb_out` is high for exactly one source period (from one rising edge to the next) out of every `m_cfg` source periods. A rising edge is a strobe that arrives while that source's phase register is low. Phase registers reset low. After reset the count starts at 510, as if M were 511.
- R3: With `n_cfg` codes 0, 1, 2 and 3, `fout` flips every 1, 2, 4 and 8 source strobes. This gives a divide by 1, 2, 4 and 8 with 50% duty. After reset the ratio is 8.
- R4: A new `n_cfg` or `m_cfg` value takes effect only at the next terminal count. The half-period or M period already in progress finishes with the old value.
- R5: The `t_code` value (bit 2 is the MSB) selects `test_out`: 0 gives `cfg_sdo`, 1 gives constant 1, 2 gives `ref_out`, 3 gives `fb_out`, 4 gives `fout`, 5 gives constant 0, 6 gives `fb_out`, and 7 gives `fout` divided by 4.
- R6: With `t_code` = 6 the feedback counter counts `sclk_edge`; with `t_code` = 4 the output divider counts `sclk_edge`. Otherwise both count `vco_edge`. Strobes on the source that is not selected have no effect.
- R7: With `t_code` = 7, `test_out` flips on every 4th flip of `fout`.
- R8: During and straight after reset, `ref_out`, `fb_out` and `fout` are low.
- R9: If M is 0 or 1, `fb_out` stays high once the counter reaches its fire state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_edge | input | 1 | One-cycle strobe per crystal clock edge |
| vco_edge | input | 1 | One-cycle strobe per oscillator clock edge |
| sclk_edge | input | 1 | One-cycle strobe per serial clock edge |
| m_cfg | input | MW | Feedback divide ratio M |
| n_cfg | input | 2 | Output divider code |
| t_code | input | 3 | Debug selector code |
| cfg_sdo | input | 1 | Serial output of the configuration shift register |
| ref_out | output | 1 | Crystal divided by 16 |
| fb_out | output | 1 | Feedback counter pulse |
| fout | output | 1 | Output divider level |
| test_out | output | 1 | Debug pin |

## Verification
The bench drives an oscillator strobe and a serial strobe in the same cycle while `t_code` is 6. In that cycle the feedback counter must take its edge from the serial clock while the output divider takes its edge from the oscillator. The bench also changes `n_cfg` and `m_cfg` in the middle of a count, so that a configuration change and a terminal count fall close together, and checks that the old ratio finishes its half or period first. A step-level reference model predicts all four outputs after every strobe, and a monitor compares them.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;

    typedef enum logic [2:0] {
        TSEL_SHIFT    = 3'd0,
        TSEL_HIGH     = 3'd1,
        TSEL_REF      = 3'd2,
        TSEL_FB       = 3'd3,
        TSEL_NDIV_SER = 3'd4,
        TSEL_LOW      = 3'd5,
        TSEL_FB_SER   = 3'd6,
        TSEL_OUT_Q4   = 3'd7
    } tsel_e;

    typedef enum logic {
        HALF_LOW  = 1'b0,
        HALF_HIGH = 1'b1
    } half_e;

    typedef enum logic {
        FB_RUN  = 1'b0,
        FB_FIRE = 1'b1
    } fb_e;

endpackage

// File: rtl/edge_divider.sv
module edge_divider
    import synth_div_pkg::*;
#(
    parameter int CW          = 5,
    parameter int RESET_RATIO = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          edge_in,
    input  logic [CW-1:0] ratio,
    output logic          lvl,
    output logic          tog
);
    localparam logic [CW-1:0] ONE      = CW'(1);
    localparam logic [CW-1:0] RST_RAT  = CW'(RESET_RATIO);

    half_e         state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] act_q, act_d;
    logic [CW-1:0] ratio_safe;
    logic          last;

    assign ratio_safe = (ratio == '0) ? ONE : ratio;
    assign last       = (cnt_q == act_q - ONE);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        act_d   = act_q;
        if (edge_in) begin
            if (last) begin
                cnt_d = '0;
                act_d = ratio_safe;
                unique case (state_q)
                    HALF_LOW:  state_d = HALF_HIGH;
                    HALF_HIGH: state_d = HALF_LOW;
                endcase
            end else begin
                cnt_d = cnt_q + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HALF_LOW;
            cnt_q   <= '0;
            act_q   <= RST_RAT;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            act_q   <= act_d;
        end
    end

    always_comb begin
        lvl = (state_q == HALF_HIGH);
        tog = edge_in && last;
    end

    // R3 (also R1, R7): the level moves only after an input strobe
    assert_half_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lvl) |-> $past(edge_in));

    // R4: count never reaches the active ratio, even across a ratio change
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < act_q);

endmodule

// File: rtl/feedback_counter.sv
module feedback_counter
    import synth_div_pkg::*;
#(
    parameter int MW      = 9,
    parameter int RESET_M = 511
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          edge_in,
    input  logic          ph_in,
    input  logic [MW-1:0] m_val,
    output logic          pulse
);
    localparam logic [MW-1:0] ONE     = MW'(1);
    localparam logic [MW-1:0] RST_CNT = MW'(RESET_M - 1);

    fb_e           state_q, state_d;
    logic [MW-1:0] cnt_q, cnt_d;
    logic          rise;

    assign rise = edge_in && !ph_in;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            FB_RUN: begin
                if (rise) begin
                    if (cnt_q <= ONE) state_d = FB_FIRE;
                    else              cnt_d   = cnt_q - ONE;
                end
            end
            FB_FIRE: begin
                if (rise && (m_val > ONE)) begin
                    state_d = FB_RUN;
                    cnt_d   = m_val - ONE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FB_RUN;
            cnt_q   <= RST_CNT;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        pulse = (state_q == FB_FIRE);
    end

    // R2: the pulse edges follow rising source edges only
    assert_fb_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pulse) |-> $past(rise));

    // R2: while counting, the remaining count is never zero
    assert_fb_cnt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FB_RUN) |-> (cnt_q != '0));

endmodule

// File: rtl/synth_divchain.sv
module synth_divchain
    import synth_div_pkg::*;
#(
    parameter int MW          = 9,
    parameter int CW          = 5,
    parameter int REF_RATIO   = 16,
    parameter int Q4_RATIO    = 4,
    parameter int RESET_M     = 511,
    parameter int RESET_NCODE = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xtal_edge,
    input  logic          vco_edge,
    input  logic          sclk_edge,
    input  logic [MW-1:0] m_cfg,
    input  logic [1:0]    n_cfg,
    input  logic [2:0]    t_code,
    input  logic          cfg_sdo,
    output logic          ref_out,
    output logic          fb_out,
    output logic          fout,
    output logic          test_out
);
    localparam int NSRC = 2;
    localparam int SRC_VCO = 0;
    localparam int SRC_SER = 1;
    localparam int RESET_N_RATIO = 1 << RESET_NCODE;

    tsel_e            tsel;
    logic [NSRC-1:0]  src_edge;
    logic [NSRC-1:0]  src_ph;
    logic             m_from_ser, n_from_ser;
    logic             m_edge, m_ph, n_edge;
    logic [CW-1:0]    n_ratio;
    logic             n_tog, ref_tog, q4_tog, q4_lvl;

    assign tsel     = tsel_e'(t_code);
    assign src_edge = {sclk_edge, vco_edge};

    generate
        for (genvar gi = 0; gi < NSRC; gi++) begin : g_phase
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)           src_ph[gi] <= 1'b0;
                else if (src_edge[gi]) src_ph[gi] <= ~src_ph[gi];
            end
        end
    endgenerate

    assign m_from_ser = (tsel == TSEL_FB_SER);
    assign n_from_ser = (tsel == TSEL_NDIV_SER);
    assign m_edge     = m_from_ser ? src_edge[SRC_SER] : src_edge[SRC_VCO];
    assign m_ph       = m_from_ser ? src_ph[SRC_SER]   : src_ph[SRC_VCO];
    assign n_edge     = n_from_ser ? src_edge[SRC_SER] : src_edge[SRC_VCO];
    assign n_ratio    = CW'(1) << n_cfg;

    edge_divider #(.CW(CW), .RESET_RATIO(REF_RATIO)) u_ref_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .edge_in (xtal_edge),
        .ratio   (CW'(REF_RATIO)),
        .lvl     (ref_out),
        .tog     (ref_tog)
    );

    feedback_counter #(.MW(MW), .RESET_M(RESET_M)) u_fb_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .edge_in (m_edge),
        .ph_in   (m_ph),
        .m_val   (m_cfg),
        .pulse   (fb_out)
    );

    edge_divider #(.CW(CW), .RESET_RATIO(RESET_N_RATIO)) u_out_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .edge_in (n_edge),
        .ratio   (n_ratio),
        .lvl     (fout),
        .tog     (n_tog)
    );

    edge_divider #(.CW(CW), .RESET_RATIO(Q4_RATIO)) u_q4_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .edge_in (n_tog),
        .ratio   (CW'(Q4_RATIO)),
        .lvl     (q4_lvl),
        .tog     (q4_tog)
    );

    always_comb begin
        unique case (tsel)
            TSEL_SHIFT:    test_out = cfg_sdo;
            TSEL_HIGH:     test_out = 1'b1;
            TSEL_REF:      test_out = ref_out;
            TSEL_FB:       test_out = fb_out;
            TSEL_NDIV_SER: test_out = fout;
            TSEL_LOW:      test_out = 1'b0;
            TSEL_FB_SER:   test_out = fb_out;
            TSEL_OUT_Q4:   test_out = q4_lvl;
        endcase
    end

    // R1: reference level moves only after a crystal strobe
    assert_ref_src_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ref_out) |-> $past(xtal_edge));

    // R6: feedback counter is deaf to the serial clock outside code 6
    assert_fb_iso_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!m_from_ser && !vco_edge) |=> $stable(fb_out));

    // R6: output divider is deaf to the serial clock outside code 4
    assert_out_iso_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!n_from_ser && !vco_edge) |=> $stable(fout));

    // R7: divide-by-4 monitor moves only on an output flip
    assert_q4_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q4_tog |-> n_tog);

endmodule

// File: tb/test_synth_divchain.sv
module test_synth_divchain;

    localparam int MW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          xtal_edge = 1'b0, vco_edge = 1'b0, sclk_edge = 1'b0;
    logic [MW-1:0] m_cfg = 9'd511;
    logic [1:0]    n_cfg = 2'd3;
    logic [2:0]    t_code = 3'd0;
    logic          cfg_sdo = 1'b0;
    logic          ref_out, fb_out, fout, test_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    synth_divchain i_synth_divchain (
        .clk(clk), .rst_n(rst_n), .xtal_edge(xtal_edge), .vco_edge(vco_edge),
        .sclk_edge(sclk_edge), .m_cfg(m_cfg), .n_cfg(n_cfg), .t_code(t_code),
        .cfg_sdo(cfg_sdo), .ref_out(ref_out), .fb_out(fb_out), .fout(fout),
        .test_out(test_out)
    );

    typedef struct {
        string tag;
        logic  r, f, o, t;
    } exp_t;
    exp_t sb_q[$];

    // reference model state
    int   rcnt = 0;  logic rlvl = 0;
    int   ncnt = 0;  int nact = 8;  logic nlvl = 0;
    int   qcnt = 0;  logic qlvl = 0;
    int   mcnt = 510; logic mfire = 0;
    logic vph = 0, sph = 0;

    function automatic logic exp_test();
        case (t_code)
            3'd0: return cfg_sdo;
            3'd1: return 1'b1;
            3'd2: return rlvl;
            3'd3: return mfire;
            3'd4: return nlvl;
            3'd5: return 1'b0;
            3'd6: return mfire;
            default: return qlvl;
        endcase
    endfunction

    task automatic chk(string tag, string nm, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", tag, nm, act, exp);
        end
    endtask

    task automatic push(string tag);
        exp_t e;
        e.tag = tag; e.r = rlvl; e.f = mfire; e.o = nlvl; e.t = exp_test();
        sb_q.push_back(e);
    endtask

    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk(e.tag, "ref_out",  ref_out,  e.r);
            chk(e.tag, "fb_out",   fb_out,   e.f);
            chk(e.tag, "fout",     fout,     e.o);
            chk(e.tag, "test_out", test_out, e.t);
        end
    end

    task automatic model(bit x, bit v, bit s);
        bit msel_ser, nsel_ser, mrise, nedge;
        msel_ser = (t_code == 3'd6);
        nsel_ser = (t_code == 3'd4);
        if (x) begin
            rcnt++;
            if (rcnt == 16) begin rlvl = ~rlvl; rcnt = 0; end
        end
        mrise = msel_ser ? (s && !sph) : (v && !vph);
        if (mrise) begin
            if (mfire) begin
                if (m_cfg > 1) begin mfire = 0; mcnt = int'(m_cfg) - 1; end
            end else if (mcnt <= 1) mfire = 1;
            else mcnt--;
        end
        nedge = nsel_ser ? s : v;
        if (nedge) begin
            ncnt++;
            if (ncnt == nact) begin
                nlvl = ~nlvl; ncnt = 0; nact = 1 << n_cfg;
                qcnt++;
                if (qcnt == 4) begin qlvl = ~qlvl; qcnt = 0; end
            end
        end
        if (v) vph = ~vph;
        if (s) sph = ~sph;
    endtask

    task automatic step(string tag, bit x, bit v, bit s);
        @(negedge clk);
        xtal_edge = x; vco_edge = v; sclk_edge = s;
        @(posedge clk);
        #1;
        xtal_edge = 0; vco_edge = 0; sclk_edge = 0;
        model(x, v, s);
        push(tag);
    endtask

    task automatic cfg(logic [2:0] t, logic [MW-1:0] m, logic [1:0] n, logic sdo);
        @(posedge clk);
        #1;
        t_code = t; m_cfg = m; n_cfg = n; cfg_sdo = sdo;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R8: reset state
        chk("R8", "ref_out", ref_out, 1'b0);
        chk("R8", "fb_out",  fb_out,  1'b0);
        chk("R8", "fout",    fout,    1'b0);
        chk("R8", "test_out", test_out, 1'b0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R8", "fout", fout, 1'b0);

        // R1: reference divide by 16
        cfg(3'd2, 9'd511, 2'd3, 1'b0);
        for (int i = 0; i < 70; i++) step("R1", 1, 0, 0);

        // R3: each output ratio, R4: changes land at terminal count
        for (int c = 0; c < 4; c++) begin
            cfg(3'd0, 9'd511, 2'(c), 1'b0);
            for (int i = 0; i < 40; i++) step("R3", 0, 1, 0);
        end
        cfg(3'd0, 9'd511, 2'd3, 1'b0);
        for (int i = 0; i < 3; i++) step("R4", 0, 1, 0);
        cfg(3'd0, 9'd511, 2'd1, 1'b0);
        for (int i = 0; i < 20; i++) step("R4", 0, 1, 0);

        // R2: feedback counter from reset count, then M = 5
        cfg(3'd3, 9'd5, 2'd0, 1'b0);
        for (int i = 0; i < 1060; i++) step("R2", 0, 1, 0);
        // R4: M change mid period
        cfg(3'd3, 9'd3, 2'd0, 1'b0);
        for (int i = 0; i < 30; i++) step("R4", 0, 1, 0);
        // R9: M of 1 holds the pulse high
        cfg(3'd3, 9'd1, 2'd0, 1'b0);
        for (int i = 0; i < 16; i++) step("R9", 0, 1, 0);
        cfg(3'd3, 9'd4, 2'd0, 1'b0);
        for (int i = 0; i < 20; i++) step("R2", 0, 1, 0);

        // R6: serial strobes ignored outside codes 4 and 6
        cfg(3'd0, 9'd4, 2'd1, 1'b1);
        for (int i = 0; i < 20; i++) step("R6", 0, 0, 1);
        cfg(3'd6, 9'd3, 2'd1, 1'b0);
        for (int i = 0; i < 30; i++) step("R6", 0, 0, 1);
        // R6: simultaneous strobes, M from serial and N from oscillator
        for (int i = 0; i < 30; i++) step("R6", 0, 1, 1);
        cfg(3'd4, 9'd3, 2'd1, 1'b0);
        for (int i = 0; i < 30; i++) step("R6", 0, 0, 1);
        for (int i = 0; i < 20; i++) step("R6", 0, 1, 0);
        for (int i = 0; i < 20; i++) step("R6", 0, 1, 1);

        // R5: every selector code
        for (int c = 0; c < 8; c++) begin
            cfg(3'(c), 9'd3, 2'd0, 1'b1);
            step("R5", 1, 1, 0);
            cfg(3'(c), 9'd3, 2'd0, 1'b0);
            step("R5", 0, 1, 0);
        end

        // R7: output divided by 4 on the debug pin
        cfg(3'd7, 9'd3, 2'd0, 1'b0);
        for (int i = 0; i < 40; i++) step("R7", 0, 1, 0);
        cfg(3'd7, 9'd3, 2'd1, 1'b0);
        for (int i = 0; i < 40; i++) step("R7", 1, 1, 0);

        repeat (3) @(posedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule